// File: doc/BRIEF.md
# Timestamp, Interval Timer and Watchdog Unit

This block is the system timer unit of a larger chip. It exposes nine 32-bit registers through a plain word-wide read/write port. It contains four timing elements. A free-running timestamp counter. Two interval timers that count down from a programmed value and can either repeat or stop after one expiry. A watchdog whose registers can only be changed after a key value has been written.

A shared status word holds one pending flag per event plus a sticky warm-reset flag. Software clears each flag by writing a one to it. Each pending flag drives its own interrupt line. The watchdog interrupt is also gated by its interrupt enable. A watchdog expiry with reset enabled produces a single-cycle reset request, which the chip's reset controller consumes.

Each interval timer is a two-state machine:
- The states are `TMR_IDLE` and `TMR_COUNT`.
- Transitions: *arm* (write a reload word with bit 0 set), *disarm* (write it with bit 0 clear), *single-shot done* (expiry in one-shot mode).

The watchdog is a three-state machine:
- The states are `WD_STOP`, `WD_RUN` and `WD_FIRE`.
- Transitions: *start* (STOP to RUN on an unlocked control write with bit 2 set), *halt* (RUN to STOP on a control write with bit 2 clear), *expire-quiet* (RUN to STOP at zero with reset disabled), *expire-reset* (RUN to FIRE at zero with reset enabled), *release* (FIRE to STOP after one cycle, or FIRE to RUN if a start write lands then).

Top module: `systimer_unit`

## Requirements
- R1: After reset, every register reads 0 except the timestamp. This includes both timer counts, both reload words, the watchdog count, the watchdog control, the lock indicator and the status word. All interrupt lines and `reset_req` are low.
- R2: The word at byte offset 0x00 is the timestamp counter. It adds one every clock cycle and wraps from 0xFFFFFFFF to 0. A write loads it. The wrap sets status bit 2.
- R3: Timer 1 uses count offset 0x04 and reload offset 0x08. Timer 2 uses count offset 0x0C and reload offset 0x10. In a reload word, bit 0 is the enable and bit 1 selects one-shot. Writing a reload word with bit 0 set loads the count with the written value and its two low bits forced to 0. The reload word reads back as {value[31:2], one-shot, running}.
- R4: In repeating mode, a timer armed with value V sets its pending bit V+1 cycles after the arming write. After that it sets the bit again every V+1 cycles. Timer 1 uses status bit 0 and timer 2 uses status bit 1.
- R5: In one-shot mode, a timer sets its pending bit once. It then clears its enable bit and keeps the count at 0.
- R6: The lock indicator at offset 0x1C reads 1 only while the last key written there was 0x482E. Any other key value relocks the watchdog. While locked, writes to the watchdog count (0x14) and watchdog control (0x18) are ignored.
- R7: Watchdog control bits are: bit 0 reset enable, bit 1 interrupt enable, bit 2 count enable. While counting, the watchdog count decrements each cycle. The cycle after it reads 0, the watchdog sets status bit 3 and clears its count-enable bit. `irq_wdg` is high while bit 3 is set and the interrupt enable is set.
- R8: Write the key, write 0 to the count, then write 0x5 to the control register. `reset_req` is then high for exactly the one cycle after the control write, and low again the cycle after.
- R9: Every reset request also sets status bit 4 (warm reset) in the same cycle. That bit stays set until a write to status with bit 4 set.
- R10: Writing the status word (0x20) clears each bit written as one and leaves the others. A set event has priority over a clear in the same cycle. `irq_t1`, `irq_t2` and `irq_ts` follow status bits 0, 1 and 2.
- R11: A read presented with `rd_en` in one cycle appears on `rdata` after the next clock edge. The byte address is decoded on bits [5:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_t1 | output | 1 | Timer 1 pending |
| irq_t2 | output | 1 | Timer 2 pending |
| irq_ts | output | 1 | Timestamp wrap pending |
| irq_wdg | output | 1 | Watchdog pending and interrupt enabled |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
The timers are exercised with two distinct programming patterns:
- A repeating timer with an aligned value is checked over three expiries. This pins the V+1 period and separates an off-by-one in reload from one in arming.
- A one-shot timer is armed with a value whose low bits are nonzero. Its count readback shows the masking, and a long quiet window afterwards proves it stopped.

The watchdog is tried three ways:
- Locked, with a wrong key and again after relocking. The count and control must stay at zero.
- With the zero-count immediate-reset sequence, which must fire on the very next cycle and only once.
- Counting from ten with only the interrupt enabled. This distinguishes the interrupt path from the reset path.

The timestamp is preloaded near its limit so the wrap flag, and its write-one-to-clear, can be seen within a few cycles.

// File: rtl/systimer_pkg.sv
package systimer_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int NUM_TMR = 2;
    localparam int STAT_W  = 5;

    typedef logic [IDX_W-1:0] reg_idx_t;

    // word indices; the timers repeat in count/reload pairs from IDX_TMR_BASE
    localparam reg_idx_t IDX_TS       = reg_idx_t'(0);
    localparam int       IDX_TMR_BASE = 1;
    localparam reg_idx_t IDX_WDCNT    = reg_idx_t'(5);
    localparam reg_idx_t IDX_WDCTL    = reg_idx_t'(6);
    localparam reg_idx_t IDX_KEY      = reg_idx_t'(7);
    localparam reg_idx_t IDX_STAT     = reg_idx_t'(8);

    // status bit positions
    localparam int ST_TS   = 2;
    localparam int ST_WD   = 3;
    localparam int ST_WARM = 4;

    // control bit positions
    localparam int RLD_EN    = 0;
    localparam int RLD_SHOT  = 1;
    localparam int WCTL_RST  = 0;
    localparam int WCTL_IRQ  = 1;
    localparam int WCTL_CNT  = 2;

    localparam logic [DATA_W-1:0] WD_UNLOCK_KEY = 32'h0000_482E;

    typedef enum logic {
        TMR_IDLE,
        TMR_COUNT
    } tmr_state_e;

    typedef enum logic [1:0] {
        WD_STOP,
        WD_RUN,
        WD_FIRE
    } wd_state_e;

endpackage

// File: rtl/systimer_stamp.sv
module systimer_stamp
    import systimer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ts,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ts_val,
    output logic         wrap
);

    logic [W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (wr_ts) begin
            ts_q <= wdata;
        end else begin
            ts_q <= ts_q + W'(1);
        end
    end

    // roll-over from all ones back to zero
    always_comb begin
        wrap   = !wr_ts && (ts_q == {W{1'b1}});
        ts_val = ts_q;
    end

endmodule

// File: rtl/systimer_interval.sv
module systimer_interval
    import systimer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cnt,
    input  logic         wr_rld,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] rld_view,
    output logic         expire
);

    localparam int BASE_W = W - 2;

    tmr_state_e        state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic              shot_q;
    logic [W-1:0]      cnt_q;
    logic              at_zero;

    assign at_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, disarm, single-shot done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (wr_rld && wdata[RLD_EN]) begin
                    state_d = TMR_COUNT;
                end
            end
            TMR_COUNT: begin
                if (wr_rld && !wdata[RLD_EN]) begin
                    state_d = TMR_IDLE;
                end else if (!wr_rld && at_zero && shot_q) begin
                    state_d = TMR_IDLE;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // datapath: reload word and down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            shot_q <= 1'b0;
            cnt_q  <= '0;
        end else if (wr_rld) begin
            base_q <= wdata[W-1:2];
            shot_q <= wdata[RLD_SHOT];
            if (wdata[RLD_EN]) begin
                cnt_q <= {wdata[W-1:2], 2'b00};
            end
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (state_q == TMR_COUNT) begin
            if (!at_zero) begin
                cnt_q <= cnt_q - W'(1);
            end else if (!shot_q) begin
                cnt_q <= {base_q, 2'b00};
            end
        end
    end

    // outputs
    always_comb begin
        expire   = (state_q == TMR_COUNT) && !wr_rld && at_zero;
        count    = cnt_q;
        rld_view = {base_q, shot_q, state_q == TMR_COUNT};
    end

endmodule

// File: rtl/systimer_watchdog.sv
module systimer_watchdog
    import systimer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_key,
    input  logic         wr_cnt,
    input  logic         wr_ctl,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] ctl_view,
    output logic         unlocked,
    output logic         running,
    output logic         irq_en,
    output logic         expire,
    output logic         fire_start,
    output logic         reset_req
);

    wd_state_e    state_q, state_d;
    logic [W-1:0] key_q;
    logic [W-1:0] cnt_q;
    logic         rst_en_q;
    logic         irq_en_q;
    logic         open_w;
    logic         ctl_ok;
    logic         cnt_ok;

    assign open_w = (key_q == WD_UNLOCK_KEY);
    assign ctl_ok = wr_ctl && open_w;
    assign cnt_ok = wr_cnt && open_w;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, halt, expire-quiet, expire-reset, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_STOP: begin
                if (ctl_ok && wdata[WCTL_CNT]) begin
                    state_d = WD_RUN;
                end
            end
            WD_RUN: begin
                if (ctl_ok) begin
                    state_d = wdata[WCTL_CNT] ? WD_RUN : WD_STOP;
                end else if (cnt_q == '0) begin
                    state_d = rst_en_q ? WD_FIRE : WD_STOP;
                end
            end
            WD_FIRE: begin
                state_d = (ctl_ok && wdata[WCTL_CNT]) ? WD_RUN : WD_STOP;
            end
            default: state_d = WD_STOP;
        endcase
    end

    // key, control and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            cnt_q    <= '0;
            rst_en_q <= 1'b0;
            irq_en_q <= 1'b0;
        end else begin
            if (wr_key) begin
                key_q <= wdata;
            end
            if (ctl_ok) begin
                rst_en_q <= wdata[WCTL_RST];
                irq_en_q <= wdata[WCTL_IRQ];
            end
            if (cnt_ok) begin
                cnt_q <= wdata;
            end else if (state_q == WD_RUN && cnt_q != '0) begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        expire     = (state_q == WD_RUN) && !ctl_ok && (cnt_q == '0);
        fire_start = expire && rst_en_q;
        reset_req  = (state_q == WD_FIRE);
        running    = (state_q == WD_RUN);
        unlocked   = open_w;
        irq_en     = irq_en_q;
        count      = cnt_q;
        ctl_view   = '0;
        ctl_view[WCTL_RST] = rst_en_q;
        ctl_view[WCTL_IRQ] = irq_en_q;
        ctl_view[WCTL_CNT] = running;
    end

endmodule

// File: rtl/systimer_unit.sv
module systimer_unit
    import systimer_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq_t1,
    output logic          irq_t2,
    output logic          irq_ts,
    output logic          irq_wdg,
    output logic          reset_req
);

    reg_idx_t            widx;
    logic [W-1:0]        ts_val;
    logic                ts_wrap;
    logic [W-1:0]        tmr_cnt [NUM_TMR];
    logic [W-1:0]        tmr_rld [NUM_TMR];
    logic [NUM_TMR-1:0]  tmr_exp;
    logic [W-1:0]        wd_count;
    logic [W-1:0]        wd_ctl_view;
    logic                wd_unlocked;
    logic                wd_running;
    logic                wd_irq_en;
    logic                wd_expire;
    logic                wd_fire_start;
    logic [STAT_W-1:0]   status_q;
    logic [STAT_W-1:0]   stat_set;
    logic [STAT_W-1:0]   stat_clr;
    logic [W-1:0]        rd_nxt;

    assign widx = addr[AW-1:2];

    systimer_stamp #(.W(W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ts  (wr_en && widx == IDX_TS),
        .wdata  (wdata),
        .ts_val (ts_val),
        .wrap   (ts_wrap)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        systimer_interval #(.W(W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cnt   (wr_en && widx == reg_idx_t'(IDX_TMR_BASE + 2*g)),
            .wr_rld   (wr_en && widx == reg_idx_t'(IDX_TMR_BASE + 2*g + 1)),
            .wdata    (wdata),
            .count    (tmr_cnt[g]),
            .rld_view (tmr_rld[g]),
            .expire   (tmr_exp[g])
        );
    end

    systimer_watchdog #(.W(W)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_key     (wr_en && widx == IDX_KEY),
        .wr_cnt     (wr_en && widx == IDX_WDCNT),
        .wr_ctl     (wr_en && widx == IDX_WDCTL),
        .wdata      (wdata),
        .count      (wd_count),
        .ctl_view   (wd_ctl_view),
        .unlocked   (wd_unlocked),
        .running    (wd_running),
        .irq_en     (wd_irq_en),
        .expire     (wd_expire),
        .fire_start (wd_fire_start),
        .reset_req  (reset_req)
    );

    // status: events set, write-one clears, set wins
    always_comb begin
        stat_set = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            stat_set[i] = tmr_exp[i];
        end
        stat_set[ST_TS]   = ts_wrap;
        stat_set[ST_WD]   = wd_expire;
        stat_set[ST_WARM] = wd_fire_start;
        stat_clr = (wr_en && widx == IDX_STAT) ? wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~stat_clr) | stat_set;
        end
    end

    // read mux
    always_comb begin
        rd_nxt = '0;
        if (widx == IDX_TS)    rd_nxt = ts_val;
        if (widx == IDX_WDCNT) rd_nxt = wd_count;
        if (widx == IDX_WDCTL) rd_nxt = wd_ctl_view;
        if (widx == IDX_KEY)   rd_nxt = W'(wd_unlocked);
        if (widx == IDX_STAT)  rd_nxt = W'(status_q);
        for (int i = 0; i < NUM_TMR; i++) begin
            if (widx == reg_idx_t'(IDX_TMR_BASE + 2*i))     rd_nxt = tmr_cnt[i];
            if (widx == reg_idx_t'(IDX_TMR_BASE + 2*i + 1)) rd_nxt = tmr_rld[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_nxt;
        end
    end

    always_comb begin
        irq_t1  = status_q[0];
        irq_t2  = status_q[1];
        irq_ts  = status_q[ST_TS];
        irq_wdg = status_q[ST_WD] && wd_irq_en;
    end

endmodule

// File: rtl/systimer_unit_chk.sv
module systimer_unit_chk
    import systimer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              reset_req,
    input logic              irq_t1,
    input logic              warm,
    input logic [DATA_W-1:0] ts,
    input logic [DATA_W-1:0] wd_cnt,
    input logic              wd_run,
    input logic              unlocked
);

    reg_idx_t widx;
    assign widx = addr[ADDR_W-1:2];

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R8

    AST_RST_MARKS_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> warm); // R9

    AST_WARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !(wr_en && widx == IDX_STAT && wdata[ST_WARM])) |=> warm); // R9

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && widx == IDX_TS) |=> ts == $past(ts) + 32'd1); // R2

    AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == IDX_WDCNT && !unlocked && !wd_run) |=> $stable(wd_cnt)); // R6

    AST_T1_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_t1) |-> $past(wr_en && widx == IDX_STAT && wdata[0])); // R10

endmodule

bind systimer_unit systimer_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .reset_req (reset_req),
    .irq_t1    (irq_t1),
    .warm      (status_q[4]),
    .ts        (ts_val),
    .wd_cnt    (wd_count),
    .wd_run    (wd_running),
    .unlocked  (wd_unlocked)
);

// File: tb/systimer_unit_tb_top.sv
`timescale 1ns/1ps
module systimer_unit_tb_top;

    localparam logic [5:0] A_TS    = 6'h00;
    localparam logic [5:0] A_T1C   = 6'h04;
    localparam logic [5:0] A_T1R   = 6'h08;
    localparam logic [5:0] A_T2C   = 6'h0C;
    localparam logic [5:0] A_T2R   = 6'h10;
    localparam logic [5:0] A_WDC   = 6'h14;
    localparam logic [5:0] A_WDE   = 6'h18;
    localparam logic [5:0] A_KEY   = 6'h1C;
    localparam logic [5:0] A_STAT  = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [5:0]  addr;
    logic [31:0] wdata, rdata;
    logic        irq_t1, irq_t2, irq_ts, irq_wdg, reset_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rst_pulses = 0;
    logic rd_fired = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    systimer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_t1(irq_t1), .irq_t2(irq_t2),
        .irq_ts(irq_ts), .irq_wdg(irq_wdg), .reset_req(reset_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        rd_fired <= rd_en;
        if (rst_n && reset_req) rst_pulses <= rst_pulses + 1;
    end

    // monitor: pops the scoreboard as read data appears
    always @(negedge clk) begin
        if (rd_fired) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read data", rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected item and issues the read
    task automatic rd_exp(logic [5:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq lines", {27'd0, irq_t1, irq_t2, irq_ts, irq_wdg, reset_req}, 32'd0);
        rd_exp(A_T1C, 0, "R1 t1 count");
        rd_exp(A_T1R, 0, "R1 t1 reload");
        rd_exp(A_T2C, 0, "R1 t2 count");
        rd_exp(A_T2R, 0, "R1 t2 reload");
        rd_exp(A_WDC, 0, "R1 wd count");
        rd_exp(A_WDE, 0, "R1 wd control");
        rd_exp(A_KEY, 0, "R1 lock");
        rd_exp(A_STAT, 0, "R1 status");

        // R2 timestamp load, step and wrap; R11 read latency
        wr(A_TS, 32'd100);
        @(negedge clk);
        rd_exp(A_TS, 32'd101, "R2 R11 timestamp step");
        wr(A_TS, 32'hFFFF_FFF0);
        rd_exp(A_TS, 32'hFFFF_FFF0, "R2 timestamp load");
        rd_exp(A_STAT, 0, "R2 no wrap yet");
        repeat (20) @(negedge clk);
        rd_exp(A_STAT, 32'h4, "R2 wrap pending");
        drain();
        check("R10 irq_ts follows bit 2", irq_ts, 1'b1);
        wr(A_STAT, 32'h4);
        rd_exp(A_STAT, 0, "R10 status w1c");

        // R3 R4 timer 1 repeating, value 8
        wr(A_T1R, 32'h9);
        e = cyc;
        rd_exp(A_T1C, 32'd8, "R3 t1 count loaded");
        rd_exp(A_T1R, 32'h9, "R3 t1 reload view");
        for (int k = 1; k <= 3; k++) begin
            wait_until(e + 9*k - 1);
            check("R4 t1 not yet", irq_t1, 1'b0);
            wait_until(e + 9*k);
            check("R4 t1 period expiry", irq_t1, 1'b1);
            wr(A_STAT, 32'h1);
            check("R10 t1 cleared", irq_t1, 1'b0);
        end
        wr(A_T1R, 32'h0);
        wr(A_STAT, 32'h1);
        rd_exp(A_T1R, 0, "R3 t1 disarmed");

        // R3 R5 timer 2 one-shot, low bits masked
        wr(A_T2R, 32'h0F);
        e = cyc;
        rd_exp(A_T2C, 32'd12, "R3 t2 count masked");
        wait_until(e + 12);
        check("R5 t2 not yet", irq_t2, 1'b0);
        wait_until(e + 13);
        check("R5 t2 expiry", irq_t2, 1'b1);
        rd_exp(A_T2R, 32'h0E, "R5 t2 enable cleared");
        wr(A_STAT, 32'h2);
        repeat (40) @(negedge clk);
        check("R5 t2 single expiry", irq_t2, 1'b0);
        rd_exp(A_T2C, 0, "R5 t2 count held");

        // R6 locked watchdog
        wr(A_WDC, 32'd100);
        wr(A_WDE, 32'h4);
        rd_exp(A_WDC, 0, "R6 locked count ignored");
        rd_exp(A_WDE, 0, "R6 locked control ignored");
        wr(A_KEY, 32'h482E);
        rd_exp(A_KEY, 1, "R6 unlocked");
        wr(A_KEY, 32'h1234);
        rd_exp(A_KEY, 0, "R6 relocked");
        wr(A_WDC, 32'd55);
        rd_exp(A_WDC, 0, "R6 relocked count ignored");
        drain();
        check("R6 no reset while locked", rst_pulses, 0);

        // R8 R9 immediate reset
        wr(A_KEY, 32'h482E);
        wr(A_WDC, 32'd0);
        wr(A_WDE, 32'h5);
        e = cyc;
        check("R8 no request at write", reset_req, 1'b0);
        wait_until(e + 1);
        check("R8 request next cycle", reset_req, 1'b1);
        wait_until(e + 2);
        check("R8 request one cycle", reset_req, 1'b0);
        rd_exp(A_STAT, 32'h18, "R9 warm and wd pending");
        rd_exp(A_WDE, 32'h1, "R7 count enable cleared");
        drain();
        check("R8 single pulse", rst_pulses, 1);
        wr(A_STAT, 32'h8);
        rd_exp(A_STAT, 32'h10, "R9 warm survives");
        wr(A_STAT, 32'h10);
        rd_exp(A_STAT, 0, "R9 warm w1c");

        // R7 interrupt-only watchdog from 10
        wr(A_WDC, 32'd10);
        wr(A_WDE, 32'h6);
        e = cyc;
        wait_until(e + 10);
        check("R7 wd irq not yet", irq_wdg, 1'b0);
        wait_until(e + 11);
        check("R7 wd irq expiry", irq_wdg, 1'b1);
        rd_exp(A_STAT, 32'h8, "R7 wd pending only");
        rd_exp(A_WDC, 0, "R7 wd count at zero");
        rd_exp(A_WDE, 32'h2, "R7 wd stopped");
        drain();
        check("R7 no reset without enable", rst_pulses, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule